// File: doc/BRIEF.md
# Write-Back Two-Way Data Cache

This block is a small data cache for a 32-bit core. It holds 1KB in two ways of 32 sets, and each line has four 32-bit words. Loads and stores arrive on a valid/ready request channel and carry per-byte enables. Hits are answered from the local tag and data arrays. Stores that hit update only the enabled bytes and mark the line modified. Main memory sees those bytes only when the line is evicted or explicitly flushed.

On a miss the cache picks a victim way. An empty way is always taken first; otherwise the least recently used way of the set is taken. A modified victim is written out word by word. The line is then refilled over a word-wide memory port, beginning at the word that missed and wrapping round the line. A missed load is answered as soon as its own word arrives, but no new request is accepted until the whole line is in place. A store miss allocates the line and is then applied as a hit.

Some accesses skip the arrays and make one word access in memory, with no line allocated:
- accesses flagged inhibited on the request;
- accesses whose 128MB region (address bits 31:27) has its bit set in a region-disable vector.

Two line commands are also provided. Flush writes a modified line back and then invalidates it. Invalidate drops the line without writing it back.

Top module: `dcache_wb`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0, and every line is invalid.
- R2: A load hit (op 2'b00) returns the cached word, with `rsp_valid` high from the second clock edge after the request handshake, and makes no memory access.
- R3: A store (op 2'b01) with enable bit i set replaces bits 8i+7:8i of the addressed word and leaves the other bytes unchanged; a store response returns data 0.
- R4: A load miss fills the line with exactly four memory reads, in word order w, w+1, w+2, w+3 modulo 4, where w is address bits 3:2 of the request.
- R5: A load miss raises `rsp_valid` as soon as the requested word has returned, before the next fill read is accepted.
- R6: A modified line reaches memory only on eviction or flush. It is written as four full-word writes (enables 4'hF) in word order 0 to 3, and all four complete before the first fill read.
- R7: The victim is an invalid way when the set has one; otherwise it is the way not used most recently in that set.
- R8: A load or store with `req_inhibit` high makes exactly one memory access to its own address, with the request's byte enables, and allocates no line.
- R9: A load or store whose `region_off` bit indexed by address bits 31:27 is set behaves like R8; clearing the bit restores caching for that region.
- R10: Flush (op 2'b10) of a modified line writes it back per R6 and invalidates it. Flush of a clean or absent line makes no memory access. Either way the response data is 0.
- R11: Invalidate (op 2'b11) clears the line with no memory write, so a later load refills from memory and returns memory's older data.
- R12: Only one request is in flight at a time: `req_ready` stays low while a response is pending. `rsp_valid`/`rsp_rdata` hold until `rsp_ready`, and `mem_req_valid` with its address, write flag and data holds until `mem_req_ready`. Responses come back in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| region_off | input | 32 | One bit per 128MB region; 1 disables caching there |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_op | input | 2 | 00 load, 01 store, 10 flush line, 11 invalidate line |
| req_addr | input | 32 | Byte address, word aligned |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| req_inhibit | input | 1 | Access bypasses the cache |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_rdata | output | 32 | Load data, 0 for other ops |
| mem_req_valid | output | 1 | Memory access valid |
| mem_req_ready | input | 1 | Memory access accepted |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_rsp_valid | input | 1 | Read data valid, at least one cycle after acceptance |
| mem_rdata | input | 32 | Read data |

## Verification
A hit response must appear exactly two edges after the request handshake. The bench records the cycle of each handshake and compares it with the cycle in which the response is seen, sampling on the falling edge. For a miss, the point of interest is the early response: the bench captures how many fill reads memory had accepted at the moment `rsp_valid` was first seen, and expects exactly one. Write-back ordering is checked from timestamps in the memory model's logs, and each read or write count is taken only once the response queue is empty and `req_ready` is high again. That way no trailing fill beat can be missed.

// File: rtl/dcache_pkg.sv
`timescale 1ns/1ps
package dcache_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FLUSH = 2'd2,
    OP_INVAL = 2'd3
  } dc_op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOOK = 3'd1,
    ST_WB   = 3'd2,
    ST_FILL = 3'd3,
    ST_BYP  = 3'd4
  } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
`timescale 1ns/1ps
module dc_tag_store #(
  parameter int SETS  = 32,
  parameter int TAG_W = 23,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      set_idx,
  input  logic                  wr_en,
  input  logic                  wr_way,
  input  logic                  wr_valid,
  input  logic                  wr_dirty,
  input  logic [TAG_W-1:0]      wr_tag,
  input  logic                  touch_en,
  input  logic                  touch_way,
  output logic [1:0]            vld,
  output logic [1:0]            drt,
  output logic [1:0][TAG_W-1:0] tags,
  output logic                  lru_victim
);
  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_a [SETS];
    logic [SETS-1:0]  v_a;
    logic [SETS-1:0]  d_a;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_a <= '0;
        d_a <= '0;
      end else if (wr_en && (wr_way == w[0])) begin
        v_a[set_idx] <= wr_valid;
        d_a[set_idx] <= wr_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == w[0])) tag_a[set_idx] <= wr_tag;
    end

    assign vld[w]  = v_a[set_idx];
    assign drt[w]  = d_a[set_idx];
    assign tags[w] = tag_a[set_idx];
  end

  // the stored bit names the way to evict next
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else if (touch_en) lru_q[set_idx] <= ~touch_way;
  end

  assign lru_victim = lru_q[set_idx];
endmodule

// File: rtl/dc_data_store.sv
`timescale 1ns/1ps
module dc_data_store #(
  parameter int SETS  = 32,
  parameter int WORDS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int AW = IDX_W + WSEL_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic              rd_way,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [31:0]       rd_data,
  input  logic              wr_en,
  input  logic              wr_way,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data
);
  logic [1:0][31:0] rd_w;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [31:0] arr [SETS*WORDS];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == w[0])) begin
        for (int b = 0; b < 4; b++) begin
          if (wr_be[b]) arr[AW'({set_idx, wr_word})][8*b +: 8] <= wr_data[8*b +: 8];
        end
      end
    end

    assign rd_w[w] = arr[AW'({set_idx, rd_word})];
  end

  assign rd_data = rd_w[rd_way];
endmodule

// File: rtl/dc_way_select.sv
`timescale 1ns/1ps
module dc_way_select #(
  parameter int TAG_W = 23
) (
  input  logic [1:0]            vld,
  input  logic [1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]      req_tag,
  input  logic                  lru_victim,
  output logic                  hit,
  output logic                  hit_way,
  output logic                  victim
);
  logic [1:0] hv;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign hv[w] = vld[w] && (tags[w] == req_tag);
  end

  assign hit     = |hv;
  assign hit_way = hv[1];

  always_comb begin
    if (!vld[0])      victim = 1'b0;
    else if (!vld[1]) victim = 1'b1;
    else              victim = lru_victim;
  end
endmodule

// File: rtl/dcache_wb.sv
`timescale 1ns/1ps
module dcache_wb
  import dcache_pkg::*;
#(
  parameter int SETS    = 32,
  parameter int WORDS   = 4,
  parameter int REGIONS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REGIONS-1:0] region_off,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_op,
  input  logic [31:0]        req_addr,
  input  logic [31:0]        req_wdata,
  input  logic [3:0]         req_be,
  input  logic               req_inhibit,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [31:0]        rsp_rdata,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_we,
  output logic [31:0]        mem_addr,
  output logic [31:0]        mem_wdata,
  output logic [3:0]         mem_be,
  input  logic               mem_rsp_valid,
  input  logic [31:0]        mem_rdata
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int OFF_W  = WSEL_W + 2;
  localparam int TAG_W  = 32 - IDX_W - OFF_W;
  localparam int RGN_W  = $clog2(REGIONS);
  localparam logic [WSEL_W-1:0] LAST = WSEL_W'(WORDS - 1);

  dc_state_e         state;
  dc_op_e            r_op;
  logic [31:0]       r_addr, r_wdata;
  logic [3:0]        r_be;
  logic              vway;
  logic [WSEL_W-1:0] cnt;
  logic              pend;

  logic [IDX_W-1:0]  idx;
  logic [WSEL_W-1:0] wsel, fill_word;
  logic [TAG_W-1:0]  rtag, vtag;
  logic [RGN_W-1:0]  req_rgn;
  logic              bypass_now;

  assign idx       = r_addr[OFF_W +: IDX_W];
  assign wsel      = r_addr[2 +: WSEL_W];
  assign rtag      = r_addr[31 -: TAG_W];
  assign fill_word = wsel + cnt;
  assign req_rgn   = req_addr[31 -: RGN_W];
  assign bypass_now = req_inhibit | region_off[req_rgn];

  // array control
  logic                  tw_en, tw_way, tw_valid, tw_dirty, touch_en, touch_way;
  logic [1:0]            vld, drt;
  logic [1:0][TAG_W-1:0] tags;
  logic                  lru_victim, hit, hit_way, victim;
  logic                  rd_way, dw_en, dw_way;
  logic [WSEL_W-1:0]     rd_word, dw_word;
  logic [3:0]            dw_be;
  logic [31:0]           dw_data, rd_data;

  dc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .set_idx(idx),
    .wr_en(tw_en), .wr_way(tw_way), .wr_valid(tw_valid), .wr_dirty(tw_dirty), .wr_tag(rtag),
    .touch_en(touch_en), .touch_way(touch_way),
    .vld(vld), .drt(drt), .tags(tags), .lru_victim(lru_victim)
  );

  dc_way_select #(.TAG_W(TAG_W)) u_sel (
    .vld(vld), .tags(tags), .req_tag(rtag), .lru_victim(lru_victim),
    .hit(hit), .hit_way(hit_way), .victim(victim)
  );

  dc_data_store #(.SETS(SETS), .WORDS(WORDS)) u_data (
    .clk(clk), .set_idx(idx),
    .rd_way(rd_way), .rd_word(rd_word), .rd_data(rd_data),
    .wr_en(dw_en), .wr_way(dw_way), .wr_word(dw_word), .wr_be(dw_be), .wr_data(dw_data)
  );

  assign vtag      = tags[vway];
  assign req_ready = (state == ST_IDLE) && !rsp_valid;

  always_comb begin
    tw_en = 1'b0; tw_way = vway; tw_valid = 1'b0; tw_dirty = 1'b0;
    touch_en = 1'b0; touch_way = hit_way;
    rd_way = hit_way; rd_word = wsel;
    dw_en = 1'b0; dw_way = hit_way; dw_word = wsel; dw_be = r_be; dw_data = r_wdata;
    mem_req_valid = 1'b0; mem_we = 1'b0; mem_addr = r_addr; mem_wdata = r_wdata; mem_be = r_be;
    case (state)
      ST_LOOK: begin
        if (hit) begin
          tw_way = hit_way;
          if (r_op == OP_LOAD) touch_en = 1'b1;
          if (r_op == OP_STORE) begin
            touch_en = 1'b1;
            dw_en    = 1'b1;
            tw_en    = 1'b1;
            tw_valid = 1'b1;
            tw_dirty = 1'b1;
          end
          if (r_op == OP_INVAL || (r_op == OP_FLUSH && !drt[hit_way])) tw_en = 1'b1;
        end
      end
      ST_WB: begin
        rd_way = vway;
        rd_word = cnt;
        mem_req_valid = 1'b1;
        mem_we = 1'b1;
        mem_addr = {vtag, idx, cnt, 2'b00};
        mem_wdata = rd_data;
        mem_be = 4'hF;
        if (mem_req_ready && cnt == LAST && r_op == OP_FLUSH) tw_en = 1'b1;
      end
      ST_FILL: begin
        mem_req_valid = !pend;
        mem_addr = {rtag, idx, fill_word, 2'b00};
        mem_be = 4'hF;
        if (pend && mem_rsp_valid) begin
          dw_en = 1'b1;
          dw_way = vway;
          dw_word = fill_word;
          dw_be = 4'hF;
          dw_data = mem_rdata;
          if (cnt == LAST) begin
            tw_en = 1'b1;
            tw_valid = 1'b1;
            touch_en = 1'b1;
            touch_way = vway;
          end
        end
      end
      ST_BYP: begin
        mem_req_valid = !pend;
        mem_we = (r_op == OP_STORE);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      pend <= 1'b0;
      cnt <= '0;
      vway <= 1'b0;
      r_op <= OP_LOAD;
      r_addr <= '0;
      r_wdata <= '0;
      r_be <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            r_op <= dc_op_e'(req_op);
            r_addr <= req_addr;
            r_wdata <= req_wdata;
            r_be <= req_be;
            cnt <= '0;
            pend <= 1'b0;
            state <= (bypass_now && !req_op[1]) ? ST_BYP : ST_LOOK;
          end
        end
        ST_LOOK: begin
          case (r_op)
            OP_LOAD, OP_STORE: begin
              if (hit) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= (r_op == OP_LOAD) ? rd_data : '0;
                state <= ST_IDLE;
              end else begin
                vway <= victim;
                state <= (vld[victim] && drt[victim]) ? ST_WB : ST_FILL;
              end
            end
            OP_FLUSH: begin
              if (hit && drt[hit_way]) begin
                vway <= hit_way;
                state <= ST_WB;
              end else begin
                rsp_valid <= 1'b1;
                rsp_rdata <= '0;
                state <= ST_IDLE;
              end
            end
            default: begin
              rsp_valid <= 1'b1;
              rsp_rdata <= '0;
              state <= ST_IDLE;
            end
          endcase
        end
        ST_WB: begin
          if (mem_req_ready) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              if (r_op == OP_FLUSH) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= '0;
                state <= ST_IDLE;
              end else begin
                state <= ST_FILL;
              end
            end
          end
        end
        ST_FILL: begin
          if (!pend) begin
            if (mem_req_ready) pend <= 1'b1;
          end else if (mem_rsp_valid) begin
            pend <= 1'b0;
            cnt <= cnt + 1'b1;
            if (cnt == '0 && r_op == OP_LOAD) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= mem_rdata;
            end
            if (cnt == LAST) state <= (r_op == OP_LOAD) ? ST_IDLE : ST_LOOK;
          end
        end
        ST_BYP: begin
          if (!pend) begin
            if (mem_req_ready) begin
              if (r_op == OP_STORE) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= '0;
                state <= ST_IDLE;
              end else begin
                pend <= 1'b1;
              end
            end
          end else if (mem_rsp_valid) begin
            pend <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_rdata <= mem_rdata;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dc_checker.sv
`timescale 1ns/1ps
module dc_checker #(
  parameter int WSEL_W = 2,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_we,
  input logic [31:0]       mem_addr,
  input logic [31:0]       mem_wdata,
  input logic [3:0]        mem_be,
  input logic [2:0]        state,
  input logic [WSEL_W-1:0] cnt,
  input logic [31:0]       r_addr
);
  import dcache_pkg::*;

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)
      && $stable(mem_we) && $stable(mem_wdata));

  assert_one_in_flight_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_wb_full_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'(ST_WB)) && mem_req_valid |-> mem_we && (mem_be == 4'hF));

  assert_fill_starts_at_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'(ST_FILL)) && mem_req_valid && (cnt == '0)
      |-> !mem_we && (mem_addr[OFF_W-1:2] == r_addr[OFF_W-1:2]));

  assert_bypass_own_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'(ST_BYP)) && mem_req_valid |-> (mem_addr == r_addr));
endmodule

bind dcache_wb dc_checker #(.WSEL_W(WSEL_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
  .state(state), .cnt(cnt), .r_addr(r_addr)
);

// File: tb/test_dcache_wb.sv
`timescale 1ns/1ps
module test_dcache_wb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] region_off = '0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0] req_be = '0;
  logic req_inhibit = 1'b0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic mem_req_valid, mem_req_ready = 1'b1, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0] mem_be;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #10 clk = ~clk;

  dcache_wb i_dcache_wb (
    .clk(clk), .rst_n(rst_n), .region_off(region_off),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_inhibit(req_inhibit),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit stall_en = 0, bp_en = 0, done = 0;
  logic [31:0] mem  [4096];
  logic [31:0] refm [4096];
  logic [31:0] rd_log [256];
  logic [31:0] wr_log [256];
  logic [3:0]  wr_be_log [256];
  int rd_cyc [256];
  int wr_cyc [256];
  int rd_cnt = 0, wr_cnt = 0;
  int acc_cyc = 0, last_rsp_cyc = 0, rd_at_rsp = 0;
  logic [31:0] exp_q [$];
  string tag_q [$];

  function automatic int wi(input logic [31:0] a);
    return int'(a[13:2]);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // memory model: accepts when ready, read data one cycle later
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[wi(mem_addr)][8*b +: 8] <= mem_wdata[8*b +: 8];
        wr_log[wr_cnt % 256] <= mem_addr;
        wr_be_log[wr_cnt % 256] <= mem_be;
        wr_cyc[wr_cnt % 256] <= cyc;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rdata <= mem[wi(mem_addr)];
        rd_log[rd_cnt % 256] <= mem_addr;
        rd_cyc[rd_cnt % 256] <= cyc;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  always @(negedge clk) mem_req_ready <= !(stall_en && (cyc % 5 == 2));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each response handshake
  always @(negedge clk) begin
    rsp_ready = !(bp_en && (cyc % 7 == 3));
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R12 unexpected response", rsp_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_rdata == e, t, rsp_rdata, e);
      end
      last_rsp_cyc = cyc;
      rd_at_rsp = rd_cnt;
    end
  end

  task automatic send(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] wd,
                      input logic [3:0] be, input logic inh, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = addr; req_wdata = wd; req_be = be; req_inhibit = inh;
    req_valid = 1'b1;
    acc_cyc = cyc;
    case (op)
      2'b00: exp_q.push_back(refm[wi(addr)]);
      2'b01: begin
        for (int b = 0; b < 4; b++) if (be[b]) refm[wi(addr)][8*b +: 8] = wd[8*b +: 8];
        exp_q.push_back(32'h0);
      end
      2'b11: begin
        for (int k = 0; k < 4; k++) refm[wi({addr[31:4], 4'h0}) + k] = mem[wi({addr[31:4], 4'h0}) + k];
        exp_q.push_back(32'h0);
      end
      default: exp_q.push_back(32'h0);
    endcase
    tag_q.push_back(tag);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    int r0, w0;
    logic [31:0] s;
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 32'hA500_0000 ^ (i * 32'h0001_0203);
      refm[i] = mem[i];
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", {31'h0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", {31'h0, mem_req_valid}, 32'h0);

    // R4/R5: load miss at word 2 of line 0x40
    r0 = rd_cnt;
    send(2'b00, 32'h48, 0, 4'h0, 0, "R5 load miss data");
    settle();
    chk(rd_cnt - r0 == 4, "R4 fill beats", rd_cnt - r0, 4);
    for (int k = 0; k < 4; k++)
      chk(rd_log[(r0 + k) % 256] == (32'h40 | ((32'(k) + 2) % 4) << 2), "R4 fill order",
          rd_log[(r0 + k) % 256], 32'h40 | ((32'(k) + 2) % 4) << 2);
    chk(rd_at_rsp - r0 == 1, "R5 early response", rd_at_rsp - r0, 1);

    // R2: hit latency and no traffic
    r0 = rd_cnt;
    send(2'b00, 32'h4C, 0, 4'h0, 0, "R2 load hit data");
    settle();
    chk(last_rsp_cyc - acc_cyc == 2, "R2 hit latency", last_rsp_cyc - acc_cyc, 2);
    chk(rd_cnt == r0, "R2 no memory read", rd_cnt - r0, 0);

    // R3: partial stores merge, no memory write (R6)
    w0 = wr_cnt;
    send(2'b01, 32'h48, 32'hDEADBEEF, 4'b0010, 0, "R3 store rsp");
    send(2'b01, 32'h4C, 32'h12345678, 4'b1100, 0, "R3 store rsp");
    send(2'b00, 32'h48, 0, 4'h0, 0, "R3 merged byte");
    send(2'b00, 32'h4C, 0, 4'h0, 0, "R3 merged half");
    settle();
    chk(wr_cnt == w0, "R6 no write on store hit", wr_cnt - w0, 0);

    // R7 victim choice, R6 dirty eviction, all in set 4
    w0 = wr_cnt; r0 = rd_cnt;
    send(2'b00, 32'h240, 0, 4'h0, 0, "R7 load");
    settle();
    chk(wr_cnt == w0 && rd_cnt - r0 == 4, "R7 invalid way first", wr_cnt - w0, 0);
    send(2'b00, 32'h40, 0, 4'h0, 0, "R7 load");
    send(2'b00, 32'h440, 0, 4'h0, 0, "R7 load");
    settle();
    chk(wr_cnt == w0, "R7 clean LRU victim", wr_cnt - w0, 0);
    r0 = rd_cnt;
    send(2'b00, 32'h44, 0, 4'h0, 0, "R7 survivor");
    settle();
    chk(rd_cnt == r0, "R7 recent line kept", rd_cnt - r0, 0);
    send(2'b00, 32'h240, 0, 4'h0, 0, "R7 load");
    settle();
    w0 = wr_cnt; r0 = rd_cnt;
    send(2'b00, 32'h640, 0, 4'h0, 0, "R6 load evicting dirty");
    settle();
    chk(wr_cnt - w0 == 4, "R6 writeback beats", wr_cnt - w0, 4);
    for (int k = 0; k < 4; k++) begin
      chk(wr_log[(w0 + k) % 256] == 32'h40 + 32'(4 * k) && wr_be_log[(w0 + k) % 256] == 4'hF,
          "R6 writeback order", wr_log[(w0 + k) % 256], 32'h40 + 32'(4 * k));
    end
    chk(wr_cyc[(w0 + 3) % 256] < rd_cyc[r0 % 256], "R6 writes before fill",
        wr_cyc[(w0 + 3) % 256], rd_cyc[r0 % 256]);
    chk(mem[wi(32'h48)] == refm[wi(32'h48)], "R6 memory updated", mem[wi(32'h48)], refm[wi(32'h48)]);

    // R8 inhibited accesses
    r0 = rd_cnt;
    send(2'b00, 32'h800, 0, 4'h0, 1, "R8 inhibited load");
    settle();
    send(2'b00, 32'h800, 0, 4'h0, 1, "R8 inhibited load");
    settle();
    chk(rd_cnt - r0 == 2, "R8 one read each, no allocation", rd_cnt - r0, 2);
    w0 = wr_cnt;
    send(2'b01, 32'h804, 32'hCAFEF00D, 4'b0011, 1, "R8 inhibited store");
    settle();
    chk(wr_cnt - w0 == 1 && wr_be_log[w0 % 256] == 4'b0011, "R8 single write with enables",
        {28'h0, wr_be_log[w0 % 256]}, 32'h3);
    chk(mem[wi(32'h804)] == refm[wi(32'h804)], "R8 memory bytes", mem[wi(32'h804)], refm[wi(32'h804)]);

    // R9 region disable, region 3
    region_off = 32'h8;
    r0 = rd_cnt;
    send(2'b00, 32'h1800_0100, 0, 4'h0, 0, "R9 disabled region load");
    send(2'b00, 32'h1800_0100, 0, 4'h0, 0, "R9 disabled region load");
    settle();
    chk(rd_cnt - r0 == 2, "R9 uncached reads", rd_cnt - r0, 2);
    region_off = 32'h0;
    r0 = rd_cnt;
    send(2'b00, 32'h1800_0100, 0, 4'h0, 0, "R9 enabled region load");
    send(2'b00, 32'h1800_0100, 0, 4'h0, 0, "R9 enabled region load");
    settle();
    chk(rd_cnt - r0 == 4, "R9 cached again", rd_cnt - r0, 4);

    // R10 flush
    send(2'b01, 32'hA0, 32'h0BADC0DE, 4'hF, 0, "R10 store");
    settle();
    w0 = wr_cnt;
    send(2'b10, 32'hA0, 0, 4'h0, 0, "R10 flush rsp");
    settle();
    chk(wr_cnt - w0 == 4, "R10 dirty flush writes", wr_cnt - w0, 4);
    chk(mem[wi(32'hA0)] == 32'h0BADC0DE, "R10 flushed data", mem[wi(32'hA0)], 32'h0BADC0DE);
    r0 = rd_cnt;
    send(2'b00, 32'hA0, 0, 4'h0, 0, "R10 reload");
    settle();
    chk(rd_cnt - r0 == 4, "R10 line invalidated", rd_cnt - r0, 4);
    w0 = wr_cnt;
    send(2'b10, 32'hA0, 0, 4'h0, 0, "R10 clean flush rsp");
    settle();
    chk(wr_cnt == w0, "R10 clean flush silent", wr_cnt - w0, 0);

    // R11 invalidate drops dirty data
    send(2'b01, 32'hC4, 32'h55AA55AA, 4'hF, 0, "R11 store");
    settle();
    w0 = wr_cnt;
    send(2'b11, 32'hC4, 0, 4'h0, 0, "R11 invalidate rsp");
    settle();
    chk(wr_cnt == w0, "R11 no writeback", wr_cnt - w0, 0);
    r0 = rd_cnt;
    send(2'b00, 32'hC4, 0, 4'h0, 0, "R11 old memory data");
    settle();
    chk(rd_cnt - r0 == 4, "R11 refill", rd_cnt - r0, 4);

    // R12 mixed traffic under stalls and response back-pressure
    stall_en = 1; bp_en = 1;
    s = 32'h1234_5678;
    for (int n = 0; n < 80; n++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      send(s[1:0] == 2'b11 ? 2'b00 : s[1:0] == 2'b10 ? 2'b01 : s[1:0] == 2'b01 ? 2'b00 : s[9:8],
           32'h2000 | {20'h0, s[20:18], 3'b000, s[7:4], s[13:12], 2'b00}, s ^ 32'h9E37_79B9,
           s[31:28] | 4'h1, 0, "R12 mixed traffic");
    end
    settle();
    chk(exp_q.size() == 0, "R12 all responses seen", exp_q.size(), 0);
    done = 1;
    report();
  end
endmodule